// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block writes a run of words into a flash-type device over a simple single-master bus, one word at a time. After a start request it pulls each word from a ready/valid data source. It sends the three-write unlock and command preamble to the device, then writes the word to its target location. It then reads that location repeatedly until the device's internal program operation has finished. The word is accepted only after a full read-back matches. Then the target address steps forward by one, or the run ends.

Completion is detected through the device's data-polling convention. While the program operation is still running, bit 7 of a read returns the complement of the written bit 7. When bit 7 agrees, a second read must match the whole word. If it does not, polling starts again. Each word has a fixed read budget. A device that never settles stops the run with an error flag, and the address of the failing word stays where it was. A done pulse marks a run that finished normally.

Top module: `flp_prog_ctrl`

## Requirements
- R1: After reset, all bus strobes, `src_ready_o`, `busy_o`, `done_o` and `err_o` are low.
- R2: A `start_i` pulse while idle with a non-zero `word_count_i` captures `start_addr_i` and the count, clears `err_o`, and raises `busy_o` on the following cycle.
- R3: For each word the bus carries exactly four one-cycle write strobes, with no reads between them: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (target address, word).
- R4: Each word is taken from the source by a `src_ready_o`/`src_valid_i` handshake, with data captured in the cycle both are high, and this happens before that word's first unlock write. Words are consumed in source order.
- R5: After the data write, every read strobe addresses the target, and `bus_rdata_i` is sampled in the cycle after `bus_re_o`.
- R6: A read whose bit 7 equals the written bit 7 is followed by one verify read. If the verify read equals the full word, the word is finished. Otherwise polling resumes. Per word, the clean reads after any unsettled ones therefore number 2, or 1 when an odd number of settled-bit-7-but-wrong reads preceded them.
- R7: Word k (counting from 0) is written to `start_addr_i + k`, modulo 2^AW.
- R8: After the last word verifies, `done_o` is high for exactly one cycle, with `busy_o` low, and `err_o` stays low.
- R9: At most MAX_POLLS reads are issued per word. If the word has not verified when the budget is spent, `err_o` rises and stays high until the next accepted start. `busy_o` falls, no done pulse appears, and no further bus cycle is issued.
- R10: A `start_i` pulse while `busy_o` is high has no effect on the running sequence.
- R11: A start with `word_count_i` of zero pulses `done_o` on the next cycle and issues no bus cycle.
- R12: `bus_we_o` and `bus_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| start_addr_i | input | AW | First target word address |
| word_count_i | input | CW | Number of words to program |
| src_valid_i | input | 1 | Source word available |
| src_data_i | input | DW | Source word |
| src_ready_o | output | 1 | Sequencer is taking a word |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_we_o | output | 1 | Write strobe, one cycle per write |
| bus_re_o | output | 1 | Read strobe, data returned the next cycle |
| bus_rdata_i | input | DW | Read data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| err_o | output | 1 | Poll budget exhausted, held until next start |

## Verification
The in-line properties check on every cycle that the done pulse lasts one cycle, that an errored sequencer stays silent on the bus, and that the read budget counter never passes its limit. They also check that each sampled read was preceded by a strobe, that the preamble starts only after a fetch, that a word finishes only from a verify read, and that the address moves only by loading or a single step. Only the bench scenarios show the exact preamble contents and target addresses against the source order. The same holds for the retry after a failed verify, which depends on a device model that settles bit 7 before the rest of the word. The scenarios also cover the exact read count at timeout, the recovery after an error, and a second start ignored mid-run.

// File: rtl/flp_pkg.sv
// Shared definitions for the flash word programming sequencer.
// Assumes the device decodes the unlock preamble on the low 12 address bits.
package flp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CMD,
        S_WDAT,
        S_RD,
        S_CHK,
        S_NEXT,
        S_FIN
    } flp_state_t;

    localparam int UNLOCK_STEPS = 3;

    // Address of preamble write number step.
    function automatic logic [11:0] unlock_addr(input logic [1:0] step);
        case (step)
            2'd0:    return 12'h555;
            2'd1:    return 12'h2AA;
            default: return 12'h555;
        endcase
    endfunction

    // Data of preamble write number step.
    function automatic logic [7:0] unlock_data(input logic [1:0] step);
        case (step)
            2'd0:    return 8'hAA;
            2'd1:    return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/flp_word_ctr.sv
// Target address and remaining-word counter.
// Assumes load and advance are never requested in the same cycle.
module flp_word_ctr #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    logic [CW-1:0] remain_q;

    // Load on start, step address and decrement remaining on each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            remain_q <= '0;
        end else if (load_i) begin
            addr_o   <= base_i;
            remain_q <= count_i;
        end else if (adv_i) begin
            addr_o   <= addr_o + AW'(1);
            remain_q <= remain_q - CW'(1);
        end
    end

    assign last_o = (remain_q == CW'(1));

    // R7: address holds unless loaded or advanced
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o));

endmodule

// File: rtl/flp_poll_timer.sv
// Per-word read budget counter.
// Assumes the controller never ticks once the budget is spent.
module flp_poll_timer #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    logic [PCW-1:0] cnt_q;

    // Count reads issued for the current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + PCW'(1);
        end
    end

    assign expired_o = (cnt_q == PCW'(MAX_POLLS));

    // R9: read count never exceeds the budget
    p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PCW'(MAX_POLLS));

endmodule

// File: rtl/flp_bus_drv.sv
// Decodes controller state into bus strobes, address and write data.
// Assumes step only ranges over the preamble writes while in S_CMD.
module flp_bus_drv
    import flp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  flp_state_t    state_i,
    input  logic [1:0]    step_i,
    input  logic [AW-1:0] tgt_addr_i,
    input  logic [DW-1:0] word_i,
    output logic          we_o,
    output logic          re_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);
    // Select preamble, data write or poll read from the current state.
    always_comb begin
        we_o    = 1'b0;
        re_o    = 1'b0;
        addr_o  = tgt_addr_i;
        wdata_o = '0;
        case (state_i)
            S_CMD: begin
                we_o    = 1'b1;
                addr_o  = AW'(unlock_addr(step_i));
                wdata_o = DW'(unlock_data(step_i));
            end
            S_WDAT: begin
                we_o    = 1'b1;
                wdata_o = word_i;
            end
            S_RD: begin
                re_o    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flp_prog_ctrl.sv
// Flash word programming sequencer (top).
// Fetches words, sends unlock preamble and data write, polls bit 7, verifies,
// then advances. Assumes read data returns one cycle after the read strobe.
module flp_prog_ctrl
    import flp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int MAX_POLLS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [CW-1:0] word_count_i,
    input  logic          src_valid_i,
    input  logic [DW-1:0] src_data_i,
    output logic          src_ready_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          bus_we_o,
    output logic          bus_re_o,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int POLL_BIT = 7;

    flp_state_t    state_q;
    logic [1:0]    step_q;
    logic [DW-1:0] word_q;
    logic          verify_q;
    logic          err_q;
    logic [AW-1:0] tgt_addr;
    logic          last_word;
    logic          expired;
    logic          load;
    logic          adv;
    logic          bit_ok;
    logic          word_ok;

    assign load    = start_i && (state_q == S_IDLE);
    assign adv     = (state_q == S_NEXT) && !last_word;
    assign bit_ok  = (bus_rdata_i[POLL_BIT] == word_q[POLL_BIT]);
    assign word_ok = (bus_rdata_i == word_q);

    flp_word_ctr #(.AW(AW), .CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .adv_i   (adv),
        .base_i  (start_addr_i),
        .count_i (word_count_i),
        .addr_o  (tgt_addr),
        .last_o  (last_word)
    );

    flp_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_q == S_WDAT),
        .tick_i    (state_q == S_RD),
        .expired_o (expired)
    );

    flp_bus_drv #(.AW(AW), .DW(DW)) u_bus (
        .state_i    (state_q),
        .step_i     (step_q),
        .tgt_addr_i (tgt_addr),
        .word_i     (word_q),
        .we_o       (bus_we_o),
        .re_o       (bus_re_o),
        .addr_o     (bus_addr_o),
        .wdata_o    (bus_wdata_o)
    );

    // Main sequencing: fetch, preamble, data write, poll/verify, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            step_q   <= '0;
            word_q   <= '0;
            verify_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    err_q   <= 1'b0;
                    state_q <= (word_count_i == '0) ? S_FIN : S_FETCH;
                end
                S_FETCH: if (src_valid_i) begin
                    word_q  <= src_data_i;
                    step_q  <= '0;
                    state_q <= S_CMD;
                end
                S_CMD: begin
                    step_q <= step_q + 2'd1;
                    if (step_q == 2'(UNLOCK_STEPS - 1)) state_q <= S_WDAT;
                end
                S_WDAT: begin
                    verify_q <= 1'b0;
                    state_q  <= S_RD;
                end
                S_RD: state_q <= S_CHK;
                S_CHK: begin
                    if (verify_q && word_ok) begin
                        state_q <= S_NEXT;
                    end else begin
                        verify_q <= !verify_q && bit_ok;
                        if (expired) begin
                            err_q   <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            state_q <= S_RD;
                        end
                    end
                end
                S_NEXT: state_q <= last_word ? S_FIN : S_FETCH;
                S_FIN:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign src_ready_o = (state_q == S_FETCH);
    assign busy_o      = (state_q != S_IDLE) && (state_q != S_FIN);
    assign done_o      = (state_q == S_FIN);
    assign err_o       = err_q;

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: an errored sequencer is idle and silent
    p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !bus_we_o && !bus_re_o));

    // R5: read data is only examined right after a read strobe
    p_rd_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHK) |-> $past(bus_re_o));

    // R4: preamble begins only after a fetch
    p_fetch_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMD && step_q == 2'd0) |-> $past(state_q) == S_FETCH);

    // R6: a word finishes only from a verify read
    p_verify_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NEXT) |-> ($past(state_q) == S_CHK && $past(verify_q)));

    // R10: while busy the target address only holds or steps by one
    p_busy_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (tgt_addr == $past(tgt_addr)) || (tgt_addr == $past(tgt_addr) + AW'(1)));

endmodule

// File: tb/tb_flp_prog_ctrl.sv
module tb_flp_prog_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int MAXP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [CW-1:0] word_count_i = '0;
    logic src_valid_i = 1'b0;
    logic [DW-1:0] src_data_i;
    logic src_ready_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic bus_we_o, bus_re_o;
    logic [DW-1:0] bus_rdata_i = '0;
    logic busy_o, done_o, err_o;

    always #2 clk = ~clk;

    flp_prog_ctrl #(.AW(AW), .DW(DW), .CW(CW), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .word_count_i(word_count_i), .src_valid_i(src_valid_i), .src_data_i(src_data_i),
        .src_ready_o(src_ready_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_rdata_i(bus_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    // device model configuration and logs
    int cfg_busy = 0;
    int cfg_flaky = 0;
    int cfg_hang = -1;
    bit clr = 1'b0;
    logic [DW-1:0] src_mem [0:63];
    int src_idx = 0;
    logic [AW-1:0] wa [0:255];
    logic [DW-1:0] wd [0:255];
    int nwr = 0;
    int rdc [0:63];
    int cln [0:63];
    int pw = 0;
    int bad_rd = 0;
    int both = 0;
    int dcount = 0;
    logic [AW-1:0] ha [0:2];
    logic [DW-1:0] hd [0:2];
    logic [DW-1:0] prog_data = '0;
    logic [AW-1:0] prog_addr = '0;
    int busy_left = 0;
    int flaky_left = 0;
    bit hanging = 1'b0;

    assign src_data_i = src_mem[src_idx[5:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_clean(input int flaky);
        return (flaky % 2 == 1) ? 1 : 2;
    endfunction

    // source handshake and device model
    always @(posedge clk) begin
        if (clr) begin
            src_idx <= 0; nwr <= 0; pw <= 0; bad_rd <= 0; both <= 0;
            busy_left <= 0; flaky_left <= 0; hanging <= 1'b0;
            for (int i = 0; i < 64; i++) begin rdc[i] <= 0; cln[i] <= 0; end
            for (int i = 0; i < 3; i++) begin ha[i] <= '0; hd[i] <= '0; end
        end else begin
            if (src_valid_i && src_ready_o) src_idx <= src_idx + 1;
            if (bus_we_o && bus_re_o) both <= both + 1;
            if (bus_we_o) begin
                if (nwr < 256) begin wa[nwr] <= bus_addr_o; wd[nwr] <= bus_wdata_o; end
                nwr <= nwr + 1;
                if (ha[2] == 16'h555 && hd[2] == 16'hAA && ha[1] == 16'h2AA && hd[1] == 16'h55 &&
                    ha[0] == 16'h555 && hd[0] == 16'hA0) begin
                    prog_data  <= bus_wdata_o;
                    prog_addr  <= bus_addr_o;
                    busy_left  <= cfg_busy;
                    flaky_left <= cfg_flaky;
                    hanging    <= (pw == cfg_hang);
                    pw <= pw + 1;
                end
                ha[2] <= ha[1]; hd[2] <= hd[1];
                ha[1] <= ha[0]; hd[1] <= hd[0];
                ha[0] <= bus_addr_o; hd[0] <= bus_wdata_o;
            end else if (busy_left > 0) begin
                busy_left <= busy_left - 1;
            end
            if (bus_re_o) begin
                if (pw > 0 && pw <= 64) rdc[pw-1] <= rdc[pw-1] + 1;
                if (bus_addr_o != prog_addr) bad_rd <= bad_rd + 1;
                if (hanging || busy_left > 0) begin
                    bus_rdata_i <= DW'($urandom) ^ {8'h00, ~prog_data[7], 7'h00} ^ {8'h00, ($urandom % 2 == 0) ? 8'h00 : 8'h00};
                    bus_rdata_i[7] <= ~prog_data[7];
                end else if (flaky_left > 0) begin
                    bus_rdata_i <= prog_data ^ 16'h0001;
                    flaky_left <= flaky_left - 1;
                end else begin
                    bus_rdata_i <= prog_data;
                    if (pw > 0 && pw <= 64) cln[pw-1] <= cln[pw-1] + 1;
                end
            end
        end
    end

    // done pulse counter and watchdog
    always @(negedge clk) begin
        cycles++;
        if (done_o) dcount++;
        if (cycles > 150000) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // random source valid at negedge
    always @(negedge clk) src_valid_i <= ($urandom % 3) != 0;

    task automatic clear_logs();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        dcount = 0;
    endtask

    task automatic run_job(input logic [15:0] base, input int cnt, input int busy,
                           input int flaky, input int hang, input bit poke);
        int lim;
        int nw_end;
        cfg_busy = busy; cfg_flaky = flaky; cfg_hang = hang;
        for (int i = 0; i < 64; i++) src_mem[i] = DW'($urandom);
        clear_logs();
        start_addr_i = base; word_count_i = CW'(cnt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; start_addr_i = 16'h7777; word_count_i = 16'd5;
        if (cnt == 0) begin
            check(done_o == 1'b1, "R11", "done after zero-count start", done_o, 1);
        end else begin
            check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
            check(err_o == 1'b0, "R2", "err cleared by start", err_o, 0);
        end
        if (poke) begin
            repeat (25) @(negedge clk);
            check(busy_o == 1'b1, "R10", "busy before second start", busy_o, 1);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        lim = 0;
        while (!done_o && !err_o && lim < 20000) begin @(negedge clk); lim++; end
        check(lim < 20000, "R8", "run ended", lim, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8", "done one cycle", done_o, 0);
        check(busy_o == 1'b0, "R8", "busy low at end", busy_o, 0);
        check(both == 0, "R12", "strobes overlapped", both, 0);
        check(bad_rd == 0, "R5", "reads off target", bad_rd, 0);
        if (hang >= 0) begin
            nw_end = nwr;
            repeat (20) @(negedge clk);
            check(err_o == 1'b1, "R9", "err held", err_o, 1);
            check(dcount == 0, "R9", "no done on timeout", dcount, 0);
            check(nwr == nw_end, "R9", "writes after error", nwr, nw_end);
            check(nwr == 4 * (hang + 1), "R9", "writes before stop", nwr, 4 * (hang + 1));
            check(rdc[hang] == MAXP, "R9", "reads on failing word", rdc[hang], MAXP);
        end else begin
            check(err_o == 1'b0, "R8", "err low", err_o, 0);
            check(dcount == 1, "R8", "done pulses", dcount, 1);
            check(nwr == 4 * cnt, cnt == 0 ? "R11" : "R3", "write count", nwr, 4 * cnt);
            for (int k = 0; k < cnt; k++) begin
                logic [AW-1:0] ta;
                ta = base + AW'(k);
                check(wa[4*k] == 16'h555 && wd[4*k] == 16'hAA, "R3", "unlock 1", wd[4*k], 16'hAA);
                check(wa[4*k+1] == 16'h2AA && wd[4*k+1] == 16'h55, "R3", "unlock 2", wd[4*k+1], 16'h55);
                check(wa[4*k+2] == 16'h555 && wd[4*k+2] == 16'hA0, "R3", "command", wd[4*k+2], 16'hA0);
                check(wa[4*k+3] == ta, "R7", "target address", wa[4*k+3], ta);
                check(wd[4*k+3] == src_mem[k], "R4", "word data", wd[4*k+3], src_mem[k]);
                check(cln[k] == exp_clean(flaky), "R6", "clean reads", cln[k], exp_clean(flaky));
                check(rdc[k] <= MAXP, "R9", "read budget", rdc[k], MAXP);
            end
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check(!bus_we_o && !bus_re_o && !src_ready_o, "R1", "strobes in reset",
              {bus_we_o, bus_re_o, src_ready_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R1", "flags after reset", {busy_o, done_o, err_o}, 0);
        run_job(16'h0100, 4, 3, 0, -1, 1'b0);
        run_job(16'h0200, 3, 2, 2, -1, 1'b0);
        run_job(16'h0300, 3, 0, 1, -1, 1'b0);
        run_job(16'h0400, 2, 5, 3, -1, 1'b0);
        run_job(16'hFFFE, 3, 1, 0, -1, 1'b0);
        run_job(16'h0500, 6, 4, 0, -1, 1'b1);
        run_job(16'h0600, 0, 0, 0, -1, 1'b0);
        run_job(16'h0700, 5, 2, 0, 2, 1'b0);
        run_job(16'h0800, 2, 1, 0, -1, 1'b0);
        for (int j = 0; j < 8; j++) begin
            run_job(16'($urandom), 1 + int'($urandom % 12), int'($urandom % 9),
                    int'($urandom % 4), -1, 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule